// File: doc/BRIEF.md
# Programmable serial baud-rate generator

This block derives every bit-rate timing signal of a serial port from the core clock. The core clock passes through a cascade of dividers: a fixed halving stage, a prescaler that divides by 1 or by 8, a 12-bit reload counter that divides by its divisor plus one, and a second halving stage. The output of that cascade is the internal rate, which is four times the prescale factor times (divisor + 1) core cycles long. Every divider output is a one-cycle clock enable in the core clock domain.

The mode input selects the outputs the block drives. In asynchronous mode the internal rate is issued as a 16x oversampling enable, and the bit enable fires once every sixteen of those. In synchronous mode the internal rate is issued as a 2x enable, and the bit enable fires on every second one. A periodic event timer taps the same cascade. Its tick is either the internal rate itself or that rate divided by 16. The tick sets a pending interrupt, and a one-cycle acknowledge clears it. A registered serial clock pin carries a square wave. In asynchronous mode that wave runs at the internal rate or at one sixteenth of it. In synchronous mode it runs at half the internal rate. A polarity control selects whether the pin is inverted.

Top module: `baud_gen`

## Requirements
- R1: While rst_ni is low, os16_en_o, x2_en_o, bit_en_o, irq_o and sclk_o are all 0.
- R2: With mode_i = 0 (asynchronous), os16_en_o is a one-cycle pulse repeating every P = 4·(7·pre_sel_i + 1)·(div_i + 1) core cycles, and x2_en_o stays 0.
- R3: In asynchronous mode, bit_en_o pulses once every 16·P core cycles.
- R4: With mode_i = 1 (synchronous), x2_en_o pulses once every P cycles, bit_en_o pulses once every 2·P cycles, and os16_en_o stays 0.
- R5: A new div_i value takes effect at the next terminal count of the counter. The first os16_en_o interval after the change lies between the new period and the old period, and every later interval equals the new period.
- R6: With irq_en_i = 1, the interrupt is raised once every 16·P cycles when tmr_fast_i = 0, and once every P cycles when tmr_fast_i = 1.
- R7: With irq_en_i = 0, timer ticks never raise irq_o.
- R8: A one-cycle irq_ack_i clears irq_o one cycle later. If the acknowledge coincides with a timer tick, irq_o stays 1.
- R9: In asynchronous mode, sclk_o is a square wave with a period of P when sclk_div_i = 0, and 16·P when sclk_div_i = 1. In synchronous mode its period is 2·P.
- R10: Setting sclk_pol_i to 1 inverts the level of sclk_o within three cycles, and clearing it restores the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | 12 | Reload divisor; the counter divides by div_i + 1 |
| pre_sel_i | input | 1 | Prescaler: 0 divides by 1, 1 divides by 8 |
| tmr_fast_i | input | 1 | Timer rate: 1 ticks at the internal rate, 0 at one sixteenth of it |
| mode_i | input | 1 | 0 asynchronous, 1 synchronous |
| sclk_div_i | input | 1 | Clock pin rate in asynchronous mode: 0 internal rate, 1 one sixteenth of it |
| sclk_pol_i | input | 1 | Clock pin polarity: 1 inverts the pin |
| irq_en_i | input | 1 | Timer interrupt enable |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| os16_en_o | output | 1 | 16x oversampling enable (asynchronous mode) |
| x2_en_o | output | 1 | 2x enable (synchronous mode) |
| bit_en_o | output | 1 | One pulse per bit time |
| sclk_o | output | 1 | Registered serial clock pin |
| irq_o | output | 1 | Pending timer interrupt |

## Verification
A timer tick and an interrupt acknowledge can land in the same cycle. When both arrive together, the set must win over the clear. The bench provokes this with the fast timer rate selected, so that each tick coincides with os16_en_o. It leaves the interrupt pending and raises irq_ack_i in a cycle where os16_en_o is seen high. The result is correct if irq_o is still 1 one cycle later. A plain acknowledge in the following cycle must then clear it.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned CD_W     = 12;
  localparam int unsigned PRE_SLOW = 8;
  localparam int unsigned OS_RATIO = 16;
  typedef enum logic {MODE_ASYNC = 1'b0, MODE_SYNC = 1'b1} mode_e;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned SLOW = baud_pkg::PRE_SLOW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic reload_i,
  output logic en_o
);
  localparam int unsigned PW = (SLOW > 1) ? $clog2(SLOW) : 1;

  logic          half_q;
  logic          sel_q;
  logic [PW-1:0] pcnt_q;
  logic          pwrap;

  assign pwrap = (pcnt_q == PW'(SLOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      sel_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      half_q <= ~half_q;
      // prescale select only changes at a counter terminal count
      if (reload_i) sel_q <= sel_i;
      if (half_q) pcnt_q <= pwrap ? '0 : pcnt_q + 1'b1;
    end
  end

  assign en_o = half_q & (~sel_q | pwrap);
endmodule

// File: rtl/baud_reload.sv
module baud_reload #(
  parameter int unsigned CD_W = baud_pkg::CD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [CD_W-1:0] div_i,
  output logic            reload_o,
  output logic            int_en_o,
  output logic            int_sq_o
);
  logic [CD_W-1:0] cnt_q;
  logic            sq_q;

  assign reload_o = tick_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_q <= div_i;
        sq_q  <= ~sq_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign int_en_o = reload_o & sq_q;
  assign int_sq_o = sq_q;
endmodule

// File: rtl/baud_taps.sv
module baud_taps #(
  parameter int unsigned OS_RATIO = baud_pkg::OS_RATIO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_en_i,
  input  logic int_sq_i,
  input  logic mode_i,
  input  logic tmr_fast_i,
  input  logic sclk_div_i,
  input  logic sclk_pol_i,
  input  logic irq_en_i,
  input  logic irq_ack_i,
  output logic os16_en_o,
  output logic x2_en_o,
  output logic bit_en_o,
  output logic tick_o,
  output logic sclk_o,
  output logic irq_o
);
  import baud_pkg::*;
  localparam int unsigned SW = $clog2(OS_RATIO);

  logic [SW-1:0] sub_q;
  logic          wrap;
  logic          sync_m;
  logic          sclk_src;
  logic          sclk_q;
  logic          irq_q;

  assign sync_m = (mode_e'(mode_i) == MODE_SYNC);
  assign wrap   = int_en_i & (sub_q == SW'(OS_RATIO - 1));

  assign os16_en_o = int_en_i & ~sync_m;
  assign x2_en_o   = int_en_i & sync_m;
  assign bit_en_o  = sync_m ? (int_en_i & sub_q[0]) : wrap;
  assign tick_o    = tmr_fast_i ? int_en_i : wrap;

  always_comb begin
    if (sync_m)          sclk_src = sub_q[0];
    else if (sclk_div_i) sclk_src = sub_q[SW-1];
    else                 sclk_src = int_sq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      sclk_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (int_en_i) sub_q <= sub_q + 1'b1;
      sclk_q <= sclk_src ^ sclk_pol_i;
      // a new tick outranks a simultaneous acknowledge
      if (tick_o && irq_en_i) irq_q <= 1'b1;
      else if (irq_ack_i)     irq_q <= 1'b0;
    end
  end

  assign sclk_o = sclk_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned CD_W     = baud_pkg::CD_W,
  parameter int unsigned PRE_SLOW = baud_pkg::PRE_SLOW,
  parameter int unsigned OS_RATIO = baud_pkg::OS_RATIO
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CD_W-1:0] div_i,
  input  logic            pre_sel_i,
  input  logic            tmr_fast_i,
  input  logic            mode_i,
  input  logic            sclk_div_i,
  input  logic            sclk_pol_i,
  input  logic            irq_en_i,
  input  logic            irq_ack_i,
  output logic            os16_en_o,
  output logic            x2_en_o,
  output logic            bit_en_o,
  output logic            sclk_o,
  output logic            irq_o
);
  logic pre_en;
  logic reload;
  logic int_en;
  logic int_sq;
  logic tmr_tick;

  baud_prescale #(.SLOW(PRE_SLOW)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (pre_sel_i),
    .reload_i (reload),
    .en_o     (pre_en)
  );

  baud_reload #(.CD_W(CD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (pre_en),
    .div_i    (div_i),
    .reload_o (reload),
    .int_en_o (int_en),
    .int_sq_o (int_sq)
  );

  baud_taps #(.OS_RATIO(OS_RATIO)) u_taps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_en_i   (int_en),
    .int_sq_i   (int_sq),
    .mode_i     (mode_i),
    .tmr_fast_i (tmr_fast_i),
    .sclk_div_i (sclk_div_i),
    .sclk_pol_i (sclk_pol_i),
    .irq_en_i   (irq_en_i),
    .irq_ack_i  (irq_ack_i),
    .os16_en_o  (os16_en_o),
    .x2_en_o    (x2_en_o),
    .bit_en_o   (bit_en_o),
    .tick_o     (tmr_tick),
    .sclk_o     (sclk_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic os16_en_o,
  input logic x2_en_o,
  input logic bit_en_o,
  input logic irq_o,
  input logic irq_en_i,
  input logic irq_ack_i,
  input logic tmr_tick
);
  // R2
  os16_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os16_en_o |=> !os16_en_o);

  // R4
  x2_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x2_en_o |=> !x2_en_o);

  // R3
  bit_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |-> (os16_en_o || x2_en_o));

  // R7
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !irq_en_i) |=> !irq_o);

  // R8
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_tick && irq_en_i) |=> irq_o);

  // R8
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !tmr_tick) |=> !irq_o);
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .os16_en_o (os16_en_o),
  .x2_en_o   (x2_en_o),
  .bit_en_o  (bit_en_o),
  .irq_o     (irq_o),
  .irq_en_i  (irq_en_i),
  .irq_ack_i (irq_ack_i),
  .tmr_tick  (tmr_tick)
);

// File: tb/baud_gen_tb.sv
`timescale 1ns/1ps
module baud_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] div_i = '0;
  logic        pre_sel_i = 1'b0, tmr_fast_i = 1'b0, mode_i = 1'b0;
  logic        sclk_div_i = 1'b0, sclk_pol_i = 1'b0;
  logic        irq_en_i = 1'b0, irq_ack_i = 1'b0;
  logic        os16_en_o, x2_en_o, bit_en_o, sclk_o, irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0, os16_cnt = 0, x2_cnt = 0;
  bit done = 0;

  baud_gen u_dut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (os16_en_o) os16_cnt <= os16_cnt + 1;
    if (x2_en_o)   x2_cnt   <= x2_cnt + 1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return os16_en_o;
      1: return x2_en_o;
      2: return bit_en_o;
      default: return irq_o;
    endcase
  endfunction

  // sel 3: rising edge of sclk_o
  task automatic next_evt(input int sel, output int t);
    logic p;
    bit hit;
    p = sclk_o;
    hit = 0;
    while (!hit) begin
      @(negedge clk_i);
      hit = (sel == 3) ? (sclk_o && !p) : sig(sel);
      p = sclk_o;
    end
    t = cyc;
  endtask

  task automatic period(input int sel, output int per);
    int a, b;
    next_evt(sel, a);
    next_evt(sel, a);
    next_evt(sel, a);
    next_evt(sel, b);
    per = b - a;
  endtask

  task automatic cfg(input int cd, input bit p, input bit m);
    @(negedge clk_i);
    div_i = 12'(cd);
    pre_sel_i = p;
    mode_i = m;
  endtask

  task automatic irq_rise(output int t);
    logic p;
    bit hit;
    p = irq_o;
    hit = 0;
    while (!hit) begin
      @(negedge clk_i);
      hit = irq_o && !p;
      p = irq_o;
    end
    t = cyc;
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk("R1 os16", os16_en_o, 0);
    chk("R1 x2", x2_en_o, 0);
    chk("R1 bit", bit_en_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 sclk", sclk_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_async(input int cd, input bit p, input bit do_bit);
    int per, x0, exp;
    exp = 4 * (7 * p + 1) * (cd + 1);
    cfg(cd, p, 1'b0);
    x0 = x2_cnt;
    period(0, per);
    chk("R2 os16 period", per, exp);
    chk("R2 x2 idle", x2_cnt - x0, 0);
    if (do_bit) begin
      period(2, per);
      chk("R3 bit period", per, 16 * exp);
    end
  endtask

  task automatic t_sync;
    int per, o0;
    cfg(3, 1'b0, 1'b1);
    o0 = os16_cnt;
    period(1, per);
    chk("R4 x2 period", per, 16);
    period(2, per);
    chk("R4 bit period", per, 32);
    chk("R4 os16 idle", os16_cnt - o0, 0);
  endtask

  task automatic t_reload;
    int per, a, b, c;
    cfg(9, 1'b0, 1'b0);
    period(0, per);
    chk("R5 old period", per, 40);
    next_evt(0, a);
    div_i = 12'd3;
    next_evt(0, b);
    chk("R5 first interval in range", ((b - a) >= 16 && (b - a) <= 40), 1);
    next_evt(0, c);
    chk("R5 new period", c - b, 16);
    next_evt(0, a);
    chk("R5 new period again", a - c, 16);
  endtask

  task automatic t_timer;
    int a, b;
    cfg(0, 1'b0, 1'b0);
    irq_en_i = 1'b1;
    tmr_fast_i = 1'b0;
    irq_rise(a);
    irq_rise(a);
    irq_rise(b);
    chk("R6 slow timer", b - a, 64);
    cfg(3, 1'b0, 1'b0);
    tmr_fast_i = 1'b1;
    irq_rise(a);
    irq_rise(a);
    irq_rise(b);
    chk("R6 fast timer", b - a, 16);
  endtask

  task automatic t_irq_off;
    int hi;
    hi = 0;
    cfg(0, 1'b0, 1'b0);
    irq_en_i = 1'b0;
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    repeat (200) begin
      @(negedge clk_i);
      if (irq_o) hi++;
    end
    chk("R7 irq stays low", hi, 0);
  endtask

  task automatic t_collide;
    int t;
    cfg(3, 1'b0, 1'b0);
    tmr_fast_i = 1'b1;
    irq_en_i = 1'b1;
    while (!irq_o) @(negedge clk_i);
    next_evt(0, t);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    chk("R8 tick beats ack", irq_o, 1);
    chk("R8 no tick here", os16_en_o, 0);
    irq_ack_i = 1'b1;
    @(negedge clk_i);
    irq_ack_i = 1'b0;
    chk("R8 ack clears", irq_o, 0);
    irq_en_i = 1'b0;
  endtask

  task automatic t_sclk;
    int per;
    sclk_pol_i = 1'b0;
    cfg(1, 1'b0, 1'b0);
    sclk_div_i = 1'b0;
    period(3, per);
    chk("R9 sclk async div1", per, 8);
    sclk_div_i = 1'b1;
    period(3, per);
    chk("R9 sclk async div16", per, 128);
    mode_i = 1'b1;
    period(3, per);
    chk("R9 sclk sync", per, 16);
  endtask

  task automatic t_pol;
    int t;
    logic s0;
    cfg(99, 1'b0, 1'b0);
    sclk_div_i = 1'b1;
    next_evt(0, t);
    next_evt(0, t);
    repeat (2) @(negedge clk_i);
    s0 = sclk_o;
    sclk_pol_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10 inverted", sclk_o, !s0);
    sclk_pol_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 restored", sclk_o, s0);
  endtask

  initial begin
    t_reset();
    t_async(0, 1'b0, 1'b1);
    t_async(5, 1'b0, 1'b1);
    t_async(2, 1'b1, 1'b1);
    t_async(12'hFFF, 1'b0, 1'b0);
    t_sync();
    t_reload();
    t_timer();
    t_irq_off();
    t_collide();
    t_sclk();
    t_pol();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule